// File: doc/BRIEF.md
# MAC Statistics Counter Bank

This block keeps the event statistics of a token-passing media access controller and presents them to a host over a small synchronous register port. Four counters are fed by single-cycle event pulses:
- received frames, 16 bits
- received tokens, 16 bits
- lost frames, 6 bits
- errored frames, 6 bits

The two narrow counts share one host word, so a single read returns both and clears both. A host read of a counter register also clears that counter. The host cannot write any counter.

When a counter wraps from its largest value to zero, it sets a sticky overflow flag. The flag stays set until the host pulses the matching bit of a flag-clear strobe. Counting goes on while the flag is still set, so a second wrap is counted like the first.

The bank also holds the station's 16-bit short address. The host can always read it, but can write it only while the MAC-enable input is low.

Top module: `mac_stat_bank`

## Requirements
- R1: Synchronous active-low reset clears all four counters, all four overflow flags, the short-address register and `host_rdata` to zero.
- R2: Address map:
  - 0 is the frame count.
  - 1 is the token count.
  - 2 is the packed lost/error word.
  - 3 is the short address.
  - Addresses 4 to 7 read as zero.
- R2 (continued): Read data appears on `host_rdata` in the cycle after `host_rd`. In a cycle that follows no read strobe, `host_rdata` is zero.
- R3: The frame counter (event bit 0) adds one per pulse and wraps from 65535 to 0. It keeps counting, and wraps again, while its overflow flag is still set.
- R4: The token counter (event bit 1) adds one per pulse and wraps from 65535 to 0. It keeps counting while its overflow flag is still set.
- R5: In the packed word:
  - The error count (event bit 3) sits in bits 5..0, least significant bit 0.
  - The lost count (event bit 2) sits in bits 13..8, least significant bit 8.
  - Bits 7, 6, 15 and 14 always read zero.
  - Each 6-bit count wraps from 63 to 0.
- R6: A read of address 0, 1 or 2 clears the counter or counters it returns, on the same edge that captures the read data. One read of address 2 clears both 6-bit counts.
- R7: When an event pulse arrives in the same cycle as a clearing read of that counter:
  - The read returns the old value.
  - The counter afterwards holds 1.
  - No overflow flag is raised by that event.
- R8: Host writes to addresses 0, 1 and 2 change no counter.
- R9: `ovf_flag` bits are frame=0, token=1, lost=2, error=3.
  - A flag sets when its counter wraps.
  - It stays set until the same bit of `ovf_clr` is pulsed.
  - Reading the counter does not clear it.
  - A wrap in the same cycle as a clear leaves the flag set.
- R10: A write to address 3 stores `host_wdata` in the short-address register only when `mac_enable` is low, and is ignored while it is high. Bit 15 (the individual/group bit, first bit on the wire) is stored and read back in place, unaffected by any bit-order setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| mac_enable | input | 1 | MAC running; locks station parameters |
| evt_pulse | input | 4 | Event pulses: frame, token, lost, error (bits 0..3) |
| ovf_clr | input | 4 | Per-flag clear strobe |
| ovf_flag | output | 4 | Sticky overflow flags |

## Verification
The hardest situation to reach is a 16-bit counter wrapping twice without any read in between, with its flag never cleared. That takes more than 131072 consecutive event pulses. The stimulus drives frame and token pulses together for 131075 cycles with no read and no flag clear. It then reads both counts and expects 3 with both flags still set.

The narrow counts reach double wrap quickly through directed bursts of 128 pulses. Collisions of an event with a clearing read, and of a wrap with a flag clear, come both from directed cases and from a seeded random phase. That phase is compared cycle by cycle against a bench model.

// File: rtl/mac_stat_pkg.sv
// Package: shared widths and register map of the MAC statistics bank.
// Assumes a 16-bit host data path and a 3-bit address space.
package mac_stat_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int WIDE_W   = 16;   // frame and token counters
    localparam int NARROW_W = 6;    // lost and error counters
    localparam int NUM_CNT  = 4;
    localparam int LOST_LSB = 8;    // lost count base in packed word

    // counter / flag / event index
    localparam int IX_FRAME = 0;
    localparam int IX_TOKEN = 1;
    localparam int IX_LOST  = 2;
    localparam int IX_ERROR = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_FRAME  = 3'd0,
        RA_TOKEN  = 3'd1,
        RA_PACKED = 3'd2,
        RA_SHORT  = 3'd3
    } reg_addr_e;
endpackage

// File: rtl/mac_stat_counter.sv
// Module: one event counter with clear-on-read.
// Counts single-cycle pulses, wraps at its maximum, and reports the wrap.
// A clearing read in the same cycle as a pulse leaves the counter at 1;
// that pulse produces no wrap report.
module mac_stat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic         rd_clr,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] ONE     = W'(1);

    // wrap report: pulse arriving at the maximum value without a clearing read
    assign wrap = ev && !rd_clr && (cnt == CNT_MAX);

    // count register: clear on read, otherwise add each pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rd_clr) begin
            cnt <= ev ? ONE : '0;
        end else if (ev) begin
            cnt <= cnt + ONE;
        end
    end

    // R7
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> cnt == {{(W-1){1'b0}}, $past(ev)});
    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> cnt == '0);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && !rd_clr) |=> $stable(cnt));
endmodule

// File: rtl/mac_stat_flags.sv
// Module: sticky overflow flags.
// Each flag sets on its wrap pulse and clears on its own clear strobe.
// Set wins when both arrive together.
module mac_stat_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // one sticky bit per counter
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end

        // R9
        set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
        // R9
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !clr[i]) |=> flag[i]);
    end
endmodule

// File: rtl/mac_stat_addr_reg.sv
// Module: station short-address parameter register.
// Written only while the MAC is disabled, readable at any time.
// The bit order is stored as written (bit 15 is the individual/group bit).
module mac_stat_addr_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         mac_enable,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    // parameter storage, write-locked while the MAC runs
    always_ff @(posedge clk) begin
        if (!rst_n)                   value <= '0;
        else if (wr_en && !mac_enable) value <= wdata;
    end

    // R10
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mac_enable) |=> $stable(value));
    // R10
    open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mac_enable) |=> value == $past(wdata));
endmodule

// File: rtl/mac_stat_bank.sv
// Module: MAC statistics counter bank (top).
// Decodes host reads and writes, instantiates the four event counters,
// the sticky overflow flags and the short-address register, and registers
// read data one cycle after the read strobe.
// Assumes read strobes are single-cycle and host_addr is valid with them.
module mac_stat_bank
    import mac_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              mac_enable,
    input  logic [NUM_CNT-1:0] evt_pulse,
    input  logic [NUM_CNT-1:0] ovf_clr,
    output logic [NUM_CNT-1:0] ovf_flag
);
    logic [NUM_CNT-1:0] rd_sel;
    logic [NUM_CNT-1:0] wrap_v;
    logic [DATA_W-1:0]  cnt_ext [NUM_CNT];
    logic [DATA_W-1:0]  short_addr;
    logic [DATA_W-1:0]  packed_word;
    logic [DATA_W-1:0]  rd_mux;
    logic               rd_frame, rd_token, rd_packed;

    // read decode: which counters a read clears
    always_comb begin
        rd_frame  = host_rd && (host_addr == RA_FRAME);
        rd_token  = host_rd && (host_addr == RA_TOKEN);
        rd_packed = host_rd && (host_addr == RA_PACKED);
        rd_sel           = '0;
        rd_sel[IX_FRAME] = rd_frame;
        rd_sel[IX_TOKEN] = rd_token;
        rd_sel[IX_LOST]  = rd_packed;
        rd_sel[IX_ERROR] = rd_packed;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int CW = (i < 2) ? WIDE_W : NARROW_W;
        logic [CW-1:0] c;
        mac_stat_counter #(.W(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (evt_pulse[i]),
            .rd_clr (rd_sel[i]),
            .cnt    (c),
            .wrap   (wrap_v[i])
        );
        assign cnt_ext[i] = DATA_W'(c);
    end

    mac_stat_flags #(.N(NUM_CNT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap_v),
        .clr   (ovf_clr),
        .flag  (ovf_flag)
    );

    mac_stat_addr_reg #(.W(DATA_W)) u_short (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr && (host_addr == RA_SHORT)),
        .mac_enable (mac_enable),
        .wdata      (host_wdata),
        .value      (short_addr)
    );

    // packed word: error count low byte, lost count high byte, pads zero
    always_comb begin
        packed_word = '0;
        packed_word[NARROW_W-1:0]          = cnt_ext[IX_ERROR][NARROW_W-1:0];
        packed_word[LOST_LSB +: NARROW_W]  = cnt_ext[IX_LOST][NARROW_W-1:0];
    end

    // read multiplexer over the register map
    always_comb begin
        case (host_addr)
            RA_FRAME:  rd_mux = cnt_ext[IX_FRAME];
            RA_TOKEN:  rd_mux = cnt_ext[IX_TOKEN];
            RA_PACKED: rd_mux = packed_word;
            RA_SHORT:  rd_mux = short_addr;
            default:   rd_mux = '0;
        endcase
    end

    // read data register: valid the cycle after the strobe, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
        else              host_rdata <= '0;
    end

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == RA_PACKED) |=>
            (host_rdata[7:6] == 2'b00 && host_rdata[15:14] == 2'b00));
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> host_rdata == '0);
    // R8
    wr_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && evt_pulse == '0 && host_addr != RA_SHORT)
            |=> $stable(packed_word));
endmodule

// File: tb/mac_stat_bank_tb.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a cycle model kept in bench functions.
module mac_stat_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  host_addr;
    logic        host_rd, host_wr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        mac_enable;
    logic [3:0]  evt_pulse, ovf_clr, ovf_flag;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_cnt [4];
    logic [3:0]  m_flag;
    logic [15:0] m_sa, m_rd;

    always #4 clk = ~clk;   // 125 MHz

    mac_stat_bank dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mac_enable(mac_enable), .evt_pulse(evt_pulse), .ovf_clr(ovf_clr),
        .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] cmax(int i);
        return (i < 2) ? 16'hFFFF : 16'h003F;
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0:    return m_cnt[0];
            3'd1:    return m_cnt[1];
            3'd2:    return {2'b00, m_cnt[2][5:0], 2'b00, m_cnt[3][5:0]};
            3'd3:    return m_sa;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_for(logic rd, logic [2:0] a);
        if (!rd) return "R2";
        case (a)
            3'd0:    return "R3";
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(logic rd, logic wr, logic [2:0] a, logic [15:0] wd,
                              logic en, logic [3:0] ev, logic [3:0] clr);
        logic [3:0]  sel;
        logic [3:0]  wr_v;
        logic [15:0] nrd;
        nrd  = rd ? m_read(a) : 16'h0000;
        sel  = {rd && a == 3'd2, rd && a == 3'd2, rd && a == 3'd1, rd && a == 3'd0};
        wr_v = 4'b0000;
        for (int i = 0; i < 4; i++) begin
            if (sel[i]) m_cnt[i] = ev[i] ? 16'd1 : 16'd0;
            else if (ev[i]) begin
                wr_v[i]  = (m_cnt[i] == cmax(i));
                m_cnt[i] = wr_v[i] ? 16'd0 : m_cnt[i] + 16'd1;
            end
        end
        m_flag = (m_flag & ~clr) | wr_v;
        if (wr && a == 3'd3 && !en) m_sa = wd;
        m_rd = nrd;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(logic rd, logic wr, logic [2:0] a, logic [15:0] wd,
                       logic en, logic [3:0] ev, logic [3:0] clr);
        host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
        mac_enable = en; evt_pulse = ev; ovf_clr = clr;
        @(posedge clk);
        model_step(rd, wr, a, wd, en, ev, clr);
        @(negedge clk);
        chk(tag_for(rd, a), host_rdata, m_rd);
        chk("R9", {12'h000, ovf_flag}, {12'h000, m_flag});
    endtask

    task automatic rd_reg(logic [2:0] a, logic en);
        cyc(1'b1, 1'b0, a, 16'h0, en, 4'h0, 4'h0);
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        host_rd = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
        mac_enable = 0; evt_pulse = 0; ovf_clr = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 16'h0;
        m_flag = 4'h0; m_sa = 16'h0; m_rd = 16'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", host_rdata, 16'h0000);
        chk("R1", {12'h0, ovf_flag}, 16'h0000);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), 1'b0);
            chk("R1", host_rdata, 16'h0000);
        end

        // R10: short address write when disabled, ignored when enabled
        cyc(0, 1, 3'd3, 16'h8001, 1'b0, 4'h0, 4'h0);
        rd_reg(3'd3, 1'b1);
        chk("R10", host_rdata, 16'h8001);
        cyc(0, 1, 3'd3, 16'h1234, 1'b1, 4'h0, 4'h0);
        rd_reg(3'd3, 1'b1);
        chk("R10", host_rdata, 16'h8001);

        // R8: writes to counter addresses do nothing
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'hF, 4'h0);
        cyc(0, 1, 3'd0, 16'hFFFF, 1'b0, 4'h0, 4'h0);
        cyc(0, 1, 3'd1, 16'hFFFF, 1'b0, 4'h0, 4'h0);
        cyc(0, 1, 3'd2, 16'hFFFF, 1'b0, 4'h0, 4'h0);
        rd_reg(3'd0, 1'b0); chk("R8", host_rdata, 16'h0001);
        rd_reg(3'd1, 1'b0); chk("R8", host_rdata, 16'h0001);
        rd_reg(3'd2, 1'b0); chk("R8", host_rdata, 16'h0101);

        // R5 / R6: packed field positions, one read clears both
        repeat (5) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b0100, 4'h0);
        repeat (3) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b1000, 4'h0);
        rd_reg(3'd2, 1'b0); chk("R5", host_rdata, 16'h0503);
        rd_reg(3'd2, 1'b0); chk("R6", host_rdata, 16'h0000);

        // R7: event collides with clearing read
        repeat (2) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b0001, 4'h0);
        cyc(1, 0, 3'd0, 16'h0, 1'b0, 4'b0001, 4'h0);
        chk("R7", host_rdata, 16'h0002);
        rd_reg(3'd0, 1'b0); chk("R7", host_rdata, 16'h0001);

        // R5 / R9: error count double wrap, flag sticky over reads
        repeat (128) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b1000, 4'h0);
        chk("R9", {12'h0, ovf_flag}, 16'h0008);
        rd_reg(3'd2, 1'b0); chk("R5", host_rdata, 16'h0000);
        chk("R9", {12'h0, ovf_flag}, 16'h0008);
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'h0, 4'b1000);
        chk("R9", {12'h0, ovf_flag}, 16'h0000);

        // R9: wrap and clear in the same cycle, set wins
        repeat (63) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b0100, 4'h0);
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b0100, 4'b0100);
        chk("R9", {12'h0, ovf_flag}, 16'h0004);
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'h0, 4'b0100);

        // R7: event at max during clearing read gives no flag
        repeat (63) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b1000, 4'h0);
        cyc(1, 0, 3'd2, 16'h0, 1'b0, 4'b1000, 4'h0);
        chk("R7", host_rdata, 16'h003F);
        chk("R7", {12'h0, ovf_flag}, 16'h0000);

        // random traffic against the model (R2..R10)
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] cl;
            cl = (($urandom % 16) == 0) ? 4'($urandom) : 4'h0;
            cyc(($urandom % 3) == 0, ($urandom % 4) == 0, 3'($urandom),
                16'($urandom), 1'($urandom), 4'($urandom), cl);
        end

        // R3 / R4: 16-bit double wrap with the flag left set
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'h0, 4'hF);
        rd_reg(3'd0, 1'b0);
        rd_reg(3'd1, 1'b0);
        cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'h0, 4'hF);
        repeat (131075) cyc(0, 0, 3'd0, 16'h0, 1'b0, 4'b0011, 4'h0);
        chk("R3", {12'h0, ovf_flag & 4'b0011}, 16'h0003);
        rd_reg(3'd0, 1'b0); chk("R3", host_rdata, 16'h0003);
        rd_reg(3'd1, 1'b0); chk("R4", host_rdata, 16'h0003);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule